// File: doc/BRIEF.md
# I2C Wiper Position Register Slave

This block is the digital half of a bus-programmable potentiometer. It listens to the two lines of an I2C bus and keeps one 8-bit wiper position register. A bus master can write this register or read it back. It drives SDA only by pulling it low: `sda_oe_o` high means the pad pulls the line low, and low means the line is released. The register value leaves the block on a parallel port, which the analog tap decoder reads directly.

Both bus lines are sampled with the fast system clock. Each line goes through a two-flop synchronizer and then a hold-count filter, so a pulse shorter than the glitch window never reaches the edge detector. The filtered lines feed an event detector, which produces START, STOP, SCL rise and SCL fall. A protocol state machine consumes those events.

States of the state machine:
- `ST_IDLE`: waiting for a START.
- `ST_DEVID`: receiving the device identifier.
- `ST_DEVID_ACK`: acknowledging the identifier.
- `ST_REGADR`: receiving the register address.
- `ST_REGADR_ACK`: acknowledging the address.
- `ST_WDATA`: receiving the data byte.
- `ST_WDATA_ACK`: acknowledging the data byte.
- `ST_TX`: sending the register value.
- `ST_TX_ACK`: watching the master's acknowledge bit.
- `ST_DONE`: released from the bus until the next START or STOP.

Transitions:
- A STOP in any state goes to `ST_IDLE`.
- A START in any state goes to `ST_DEVID`.
- On the SCL fall after eight received bits:
  - `ST_DEVID` goes to `ST_DEVID_ACK` on a match and to `ST_DONE` otherwise.
  - `ST_REGADR` goes to `ST_REGADR_ACK` on a match and to `ST_DONE` otherwise.
  - `ST_WDATA` goes to `ST_WDATA_ACK`.
- On the SCL fall that ends an acknowledge clock:
  - `ST_DEVID_ACK` goes to `ST_TX` for a read or to `ST_REGADR` for a write.
  - `ST_REGADR_ACK` goes to `ST_WDATA`.
  - `ST_WDATA_ACK` goes to `ST_DONE`.
  - `ST_TX_ACK` goes to `ST_TX` if the master acknowledged, and to `ST_DONE` otherwise.
- `ST_TX` goes to `ST_TX_ACK` on the eighth SCL fall.

Top module: `wiper_i2c_slave`

## Requirements
- R1: Out of reset, `wiper_o` is 8'h80 and `sda_oe_o` is 0 (SDA released).
- R2: An identifier byte is accepted only when its upper seven bits are 7'b0101000. Bit 0 selects the direction: 0 is write (byte 8'h50) and 1 is read (byte 8'h51). An accepted identifier is acknowledged by pulling SDA low during the ninth clock.
- R3: Bytes are shifted most significant bit first, both when received and when sent.
- R4: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. An SDA change while SCL is low is data.
- R5: A write is START, 8'h50, address 8'h00, one data byte, then STOP. All three bytes are acknowledged.
- R6: The data byte is copied into the register on the SCL falling edge that ends its least significant bit. This is before the acknowledge clock and never earlier.
- R7: A read is START, 8'h50, 8'h00, a repeated START, then 8'h51. The slave acknowledges all three bytes and then sends the register value.
- R8: The slave keeps sending the register value while the master acknowledges after each eighth bit. After a not-acknowledge, the slave releases SDA.
- R9: A STOP returns the engine to idle. Bytes clocked after the STOP and before a new START are not acknowledged.
- R10: A pulse on SCL or SDA shorter than the glitch window (6 system clocks by default) has no effect on the protocol.
- R11: A wrong identifier, or an address other than 8'h00, gets no acknowledge. The slave then ignores every further byte until the next START, and the register is unchanged.
- R12: A STOP or START in the middle of a byte aborts the transfer and leaves the register unchanged. After a START, the new transfer proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 8 | Current wiper position register |

## Verification
Some rules are checked by the assertions on every cycle:
- The four bus events never occur together.
- The filter output changes only after the synchronized line has agreed with the new level.
- The register changes only on an SCL fall in the data-receive state.
- A STOP always lands in idle with the register held.
- A rejected identifier and a master not-acknowledge both leave SDA released.

Other behaviour can only be shown by the bench scenarios, which drive complete bus transactions:
- Correct acknowledge bits and bit order.
- Read-back of written values, and multi-byte reads.
- Rejection of glitches injected on both lines.
- Mid-byte aborts.
- The exact moment of the register commit relative to the acknowledge clock.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVID,
        ST_DEVID_ACK,
        ST_REGADR,
        ST_REGADR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_DONE
    } link_state_t;

endpackage

// File: rtl/wiper_line_filter.sv
module wiper_line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   HOLD_CYC    = 6,
    parameter logic IDLE_LVL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_q;
    logic                   filt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{IDLE_LVL}};
            run_q  <= '0;
            filt_q <= IDLE_LVL;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (synced == filt_q) begin
                run_q <= '0;
            end else if (run_q == CNT_W'(HOLD_CYC - 1)) begin
                filt_q <= synced;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign line_o = filt_q;

    // R10: a new filtered level needs at least two agreeing synchronized samples
    a_r10_level_agreed: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(synced, 1) == filt_q && $past(synced, 2) == filt_q));

endmodule

// File: rtl/wiper_bus_events.sv
module wiper_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall,
    output logic sda_lvl
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign ev_start = scl_f & scl_p & sda_p & ~sda_f;
    assign ev_stop  = scl_f & scl_p & ~sda_p & sda_f;
    assign ev_rise  = scl_f & ~scl_p;
    assign ev_fall  = ~scl_f & scl_p;
    assign sda_lvl  = sda_f;

    // R4: start, stop and clock edges are mutually exclusive events
    a_r4_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_rise, ev_fall}));

endmodule

// File: rtl/wiper_proto_fsm.sv
module wiper_proto_fsm
    import wiper_i2c_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-2:0] DEV_ID    = 7'b0101000,
    parameter logic [DATA_W-1:0] REG_ADDR  = 8'h00,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              sda_lvl,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] wiper_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    link_state_t       st_q, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sr, tx_sr, wiper_q;
    logic              rw_q, mack_q;
    logic              full, rx_state, id_hit, adr_hit;

    assign full     = (bit_cnt == CNT_W'(DATA_W));
    assign rx_state = (st_q == ST_DEVID) || (st_q == ST_REGADR) || (st_q == ST_WDATA);
    assign id_hit   = (rx_sr[DATA_W-1:1] == DEV_ID);
    assign adr_hit  = (rx_sr == REG_ADDR);

    always_comb begin
        nxt = st_q;
        if (ev_stop) begin
            nxt = ST_IDLE;
        end else if (ev_start) begin
            nxt = ST_DEVID;
        end else if (ev_fall) begin
            unique case (st_q)
                ST_DEVID:      if (full) nxt = id_hit ? ST_DEVID_ACK : ST_DONE;
                ST_DEVID_ACK:  nxt = rw_q ? ST_TX : ST_REGADR;
                ST_REGADR:     if (full) nxt = adr_hit ? ST_REGADR_ACK : ST_DONE;
                ST_REGADR_ACK: nxt = ST_WDATA;
                ST_WDATA:      if (full) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK:  nxt = ST_DONE;
                ST_TX:         if (bit_cnt == CNT_W'(DATA_W - 1)) nxt = ST_TX_ACK;
                ST_TX_ACK:     nxt = mack_q ? ST_TX : ST_DONE;
                default:       nxt = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            wiper_q <= RESET_VAL;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            st_q <= nxt;
            if (ev_start || ev_stop || nxt != st_q) begin
                bit_cnt <= '0;
            end else if (rx_state && ev_rise && !full) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sr   <= {rx_sr[DATA_W-2:0], sda_lvl};
            end else if (st_q == ST_TX && ev_fall) begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sr   <= {tx_sr[DATA_W-2:0], 1'b0};
            end
            if (nxt == ST_TX && st_q != ST_TX) tx_sr <= wiper_q;
            if (st_q == ST_TX_ACK && ev_rise) mack_q <= ~sda_lvl;
            if (st_q == ST_DEVID && ev_fall && full) rw_q <= rx_sr[0];
            if (st_q == ST_WDATA && ev_fall && full && !ev_stop && !ev_start) wiper_q <= rx_sr;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_DEVID_ACK, ST_REGADR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_TX:                                    sda_oe_o = ~tx_sr[DATA_W-1];
            default:                                  sda_oe_o = 1'b0;
        endcase
    end

    assign wiper_o = wiper_q;

    // R6: the register moves only on an SCL fall while receiving data
    a_r6_commit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_q != $past(wiper_q)) |-> ($past(st_q) == ST_WDATA && $past(ev_fall)));
    // R9: STOP always lands in idle
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (st_q == ST_IDLE));
    // R12: a STOP never changes the register
    a_r12_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> $stable(wiper_q));
    // R11: a rejected identifier gets no acknowledge
    a_r11_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEVID && ev_fall && full && !id_hit) |=> !sda_oe_o);
    // R8: a master not-acknowledge releases the line
    a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TX_ACK && ev_fall && !mack_q) |=> !sda_oe_o);

endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
    parameter int                CLK_NS      = 10,
    parameter int                GLITCH_NS   = 50,
    parameter int                SYNC_STAGES = 2,
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-2:0] DEV_ID      = 7'b0101000,
    parameter logic [DATA_W-1:0] REG_ADDR    = 8'h00,
    parameter logic [DATA_W-1:0] RESET_VAL   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] wiper_o
);
    localparam int HOLD_CYC = GLITCH_NS / CLK_NS + 1;
    localparam int N_LINES  = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic ev_start, ev_stop, ev_rise, ev_fall, sda_lvl;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        wiper_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .HOLD_CYC   (HOLD_CYC),
            .IDLE_LVL   (1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    wiper_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (filt_lines[1]),
        .sda_f   (filt_lines[0]),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall),
        .sda_lvl (sda_lvl)
    );

    wiper_proto_fsm #(
        .DATA_W   (DATA_W),
        .DEV_ID   (DEV_ID),
        .REG_ADDR (REG_ADDR),
        .RESET_VAL(RESET_VAL)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall),
        .sda_lvl (sda_lvl),
        .sda_oe_o(sda_oe_o),
        .wiper_o (wiper_o)
    );

endmodule

// File: tb/wiper_i2c_slave_bench.sv
module wiper_i2c_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 20;
    localparam int WATCHDOG   = 180000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [7:0] wiper;
    wire sda_line = sda_m & ~sda_oe;

    wiper_i2c_slave u_wiper_i2c_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .wiper_o (wiper)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_wiper = 8'h80;
    logic cmp_en = 1'b0;
    logic done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural model of the register, compared every cycle (R6 timing, R11/R12 untouched)
    always @(negedge clk) begin
        if (cmp_en) check(wiper == exp_wiper, "R6 per-cycle register model", wiper, exp_wiper);
    end

    task automatic qtr();
        repeat (Q) @(negedge clk);
    endtask
    task automatic do_start();
        sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b0; qtr(); scl_m = 1'b0; qtr();
    endtask
    task automatic do_stop();
        sda_m = 1'b0; qtr(); scl_m = 1'b1; qtr(); sda_m = 1'b1; qtr();
    endtask
    task automatic put_bit(input logic b);
        sda_m = b; qtr(); scl_m = 1'b1; qtr(); qtr(); scl_m = 1'b0; qtr();
    endtask
    task automatic get_bit(output logic b);
        sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr(); b = sda_line; qtr(); scl_m = 1'b0; qtr();
    endtask
    task automatic put8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask
    task automatic ack_clk(output logic acked);
        logic b;
        get_bit(b);
        acked = ~b;
    endtask
    task automatic send(input logic [7:0] v, output logic acked);
        put8(v);
        ack_clk(acked);
    endtask
    task automatic recv(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~mack);
    endtask

    task automatic wr(input logic [7:0] d);
        logic a0, a1, a2;
        do_start();
        send(8'h50, a0);
        check(a0, "R2 write identifier ack", a0, 1);
        send(8'h00, a1);
        for (int i = 7; i >= 1; i--) put_bit(d[i]);
        sda_m = d[0]; qtr(); scl_m = 1'b1; qtr(); qtr();
        check(wiper == exp_wiper, "R6 no commit before LSB fall", wiper, exp_wiper);
        cmp_en = 1'b0;
        scl_m = 1'b0; qtr();
        exp_wiper = d;
        check(wiper == d, "R6 commit before ack clock", wiper, d);
        cmp_en = 1'b1;
        ack_clk(a2);
        check(a1 && a2, "R5 address and data ack", {a1, a2}, 2'b11);
        do_stop();
    endtask

    task automatic rd(input int nbytes);
        logic a0, a1, a2;
        logic [7:0] v;
        do_start();
        send(8'h50, a0);
        send(8'h00, a1);
        do_start();
        send(8'h51, a2);
        check(a0 && a1 && a2, "R7 read preamble acks", {a0, a1, a2}, 3'b111);
        for (int k = 0; k < nbytes; k++) begin
            recv(k < nbytes - 1, v);
            check(v == exp_wiper, "R3 R8 read data byte", v, exp_wiper);
        end
        check(sda_line == 1'b1, "R8 released after nack", sda_line, 1);
        do_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        logic a1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(wiper == 8'h80, "R1 reset value", wiper, 8'h80);
        check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        cmp_en = 1'b1;

        // R3 asymmetric value, R5 R6 write then R7 read
        wr(8'hC5);
        rd(1);
        // boundaries
        wr(8'h00);
        rd(1);
        wr(8'hFF);
        rd(1);
        wr(8'h01);
        // R8 continuous read of three bytes
        rd(3);

        // R11 wrong identifier
        do_start();
        send(8'h52, a);
        check(!a, "R11 wrong identifier not acked", a, 0);
        send(8'h00, a);
        send(8'h99, a1);
        check(!a && !a1, "R11 bytes ignored after miss", {a, a1}, 0);
        do_stop();
        check(wiper == exp_wiper, "R11 register kept", wiper, exp_wiper);

        // R11 wrong address
        do_start();
        send(8'h50, a);
        check(a, "R2 identifier ack", a, 1);
        send(8'h01, a);
        check(!a, "R11 wrong address not acked", a, 0);
        send(8'h33, a);
        check(!a, "R11 data ignored after bad address", a, 0);
        do_stop();
        check(wiper == exp_wiper, "R11 register kept after bad address", wiper, exp_wiper);

        // R9 no START: bytes after STOP are not acknowledged
        send(8'h50, a);
        check(!a, "R9 idle ignores bytes without START", a, 0);
        do_stop();

        // R12 STOP mid data byte
        do_start();
        send(8'h50, a);
        send(8'h00, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        do_stop();
        check(wiper == exp_wiper, "R12 stop abort keeps register", wiper, exp_wiper);

        // R12 R4 START mid byte, then a full write on the new transfer
        do_start();
        send(8'h50, a);
        send(8'h00, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        check(wiper == exp_wiper, "R12 partial byte no change", wiper, exp_wiper);
        wr(8'h5A);
        rd(1);

        // R10 glitches on SCL (low phase) and SDA (high phase) during a write
        do_start();
        send(8'h50, a);
        send(8'h00, a);
        cmp_en = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (i == 4) begin
                sda_m = 1'b1; qtr(); scl_m = 1'b1; qtr();
                sda_m = 1'b0; repeat (3) @(negedge clk); sda_m = 1'b1;
                qtr(); scl_m = 1'b0; qtr();
                scl_m = 1'b1; repeat (3) @(negedge clk); scl_m = 1'b0; qtr();
            end else begin
                put_bit(8'hB6 >> i);
            end
        end
        ack_clk(a);
        exp_wiper = 8'hB6;
        check(a, "R10 data acked despite glitches", a, 1);
        check(wiper == 8'hB6, "R10 glitches rejected", wiper, 8'hB6);
        cmp_en = 1'b1;
        do_stop();
        rd(2);

        done = 1'b1;
        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule